// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Controller

This block steers the next fetch address of a five-stage in-order pipeline whose conditional branches and jumps are settled while they sit in the decode stage. It receives the instruction held in decode (its kind, source register number, forwarded operand value, 16-bit offset and the already incremented sequential PC), together with the destination of the instruction one stage ahead in execute. A private adder forms the taken target, and a zero detector settles the direction. The block then tells fetch whether to take the sequential address, the target, or to hold still, and it tells decode when the instruction now in it must be turned into a bubble.

The cost of a taken redirect is one cycle, and a two-bit policy input selects how that cycle is spent: always discard the successor (stall policy), keep the successor only when the branch falls through (predict not-taken), or always execute the successor as a delay slot. A conditional branch whose register is still being produced by the execute-stage instruction waits one cycle first, so that it compares the forwarded value.

The control is a three-state machine. `ST_RUN` is the normal state. From `ST_RUN`, a conditional branch with a register conflict goes to `ST_DEPWAIT` (one held cycle). A resolved branch or jump goes to `ST_KILL` when the policy discards its successor, and otherwise stays in `ST_RUN`. `ST_DEPWAIT` resolves the waiting branch without another conflict check, then moves to `ST_KILL` or `ST_RUN` by the same policy rule. `ST_KILL` squashes the instruction in decode and always returns to `ST_RUN`.

Top module: `branch_resolve_ctl`

## Requirements
- R1: After reset, with no branch in decode, `pc_sel_o` is 0 (sequential), `squash_o` is 0 and `hold_o` is 0.
- R2: While a branch or jump is in decode, `target_pc_o` equals `id_seq_pc_i` plus the 16-bit offset, sign-extended and multiplied by 4, modulo 2^32.
- R3: Kind codes are as follows. Kind 0 is not a branch. Kind 1 is taken when the operand is zero. Kind 2 is taken when the operand is nonzero. Kind 3 is a jump and is always taken. In the resolving cycle, `pc_sel_o` is 1 (target) when the branch is taken and 0 when it is not.
- R4: A kind 1 or 2 branch is held for exactly one cycle when all of the following are true: `ex_wr_en_i` is set, `ex_wr_reg_i` equals its nonzero source register, and no hold has just occurred. During the hold, `hold_o` is 1 and `pc_sel_o` is 2. A jump never holds. The cycle after a hold resolves the branch whatever the execute inputs are.
- R5: Under policy 0 (and the unused code 3), the cycle after any resolution has `squash_o` at 1.
- R6: Under policy 1 (predict not-taken), the cycle after a resolution has `squash_o` at 1 exactly when the branch was taken.
- R7: Under policy 2 (delay slot), `squash_o` stays 0 after a resolution, and a branch sitting in the slot is resolved normally.
- R8: In a squash cycle the decode contents are ignored: `pc_sel_o` is 0, `hold_o` is 0, and the cycle that follows has no squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| policy_i | input | 2 | Branch-cycle policy: 0 stall, 1 predict not-taken, 2 delay slot |
| id_valid_i | input | 1 | Decode holds a valid instruction |
| id_kind_i | input | 2 | Control-transfer kind of the decode instruction |
| id_src_reg_i | input | 5 | Register tested by a conditional branch |
| id_operand_i | input | 32 | Forwarded value of the tested register |
| id_offset_i | input | 16 | Signed word offset of the branch or jump |
| id_seq_pc_i | input | 32 | Address after the decode instruction |
| ex_wr_en_i | input | 1 | Execute-stage instruction writes a register |
| ex_wr_reg_i | input | 5 | Destination register of the execute-stage instruction |
| pc_sel_o | output | 2 | Next fetch address: 0 sequential, 1 target, 2 hold |
| target_pc_o | output | 32 | Computed taken target |
| squash_o | output | 1 | Turn the instruction now in decode into a bubble |
| hold_o | output | 1 | Freeze fetch and decode for this cycle |

## Verification
Target, direction select and hold are combinational on the decode inputs and the current state, so they are due in the same cycle the branch is presented. The squash is due one clock edge later, in the cycle its successor occupies decode. The bench drives inputs at the falling edge and samples a few nanoseconds later, before the next rising edge. Its model advances only at the rising edge, so every squash expectation refers to the resolution made in the previous cycle.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        SEL_SEQ  = 2'd0,
        SEL_TGT  = 2'd1,
        SEL_HOLD = 2'd2
    } nxt_sel_e;

    typedef enum logic [1:0] {
        POL_STALL = 2'd0,
        POL_PNT   = 2'd1,
        POL_DELAY = 2'd2,
        POL_RSVD  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_BEQZ = 2'd1,
        K_BNEZ = 2'd2,
        K_JUMP = 2'd3
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DEPWAIT = 2'd1,
        ST_KILL    = 2'd2
    } brc_state_e;

endpackage

// File: rtl/brc_target_add.sv
module brc_target_add #(
    parameter int XLEN        = 32,
    parameter int OFFW        = 16,
    parameter int INSTR_BYTES = 4
) (
    input  logic [XLEN-1:0] seq_pc,
    input  logic [OFFW-1:0] offset,
    output logic [XLEN-1:0] target
);
    localparam int SHIFT = $clog2(INSTR_BYTES);
    localparam int EXTW  = XLEN - OFFW;

    logic [XLEN-1:0] off_ext;

    always_comb begin
        off_ext = {{EXTW{offset[OFFW-1]}}, offset};
        target  = seq_pc + (off_ext << SHIFT);
    end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_kind_e      kind,
    input  logic [XLEN-1:0] operand,
    output logic            taken,
    output logic            reads_reg
);
    logic is_zero;

    always_comb begin
        is_zero   = (operand == '0);
        taken     = 1'b0;
        reads_reg = 1'b0;
        unique case (kind)
            K_BEQZ: begin taken = is_zero;  reads_reg = 1'b1; end
            K_BNEZ: begin taken = !is_zero; reads_reg = 1'b1; end
            K_JUMP: taken = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/branch_resolve_ctl.sv
module branch_resolve_ctl
    import brc_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int OFFW        = 16,
    parameter int REGW        = 5,
    parameter int INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      policy_i,
    input  logic            id_valid_i,
    input  logic [1:0]      id_kind_i,
    input  logic [REGW-1:0] id_src_reg_i,
    input  logic [XLEN-1:0] id_operand_i,
    input  logic [OFFW-1:0] id_offset_i,
    input  logic [XLEN-1:0] id_seq_pc_i,
    input  logic            ex_wr_en_i,
    input  logic [REGW-1:0] ex_wr_reg_i,
    output logic [1:0]      pc_sel_o,
    output logic [XLEN-1:0] target_pc_o,
    output logic            squash_o,
    output logic            hold_o
);
    brc_state_e state, state_nxt;
    policy_e    pol;
    xfer_kind_e kind;
    nxt_sel_e   sel;
    logic       taken, reads_reg, is_xfer, dep_hit, kill_next, resolved;

    assign pol  = policy_e'(policy_i);
    assign kind = xfer_kind_e'(id_kind_i);

    brc_target_add #(.XLEN(XLEN), .OFFW(OFFW), .INSTR_BYTES(INSTR_BYTES)) u_tadd (
        .seq_pc (id_seq_pc_i),
        .offset (id_offset_i),
        .target (target_pc_o)
    );

    brc_cond_eval #(.XLEN(XLEN)) u_cond (
        .kind      (kind),
        .operand   (id_operand_i),
        .taken     (taken),
        .reads_reg (reads_reg)
    );

    always_comb begin
        is_xfer = id_valid_i && (kind != K_NONE);
        dep_hit = reads_reg && ex_wr_en_i && (ex_wr_reg_i == id_src_reg_i)
                  && (id_src_reg_i != '0);
        unique case (pol)
            POL_PNT:   kill_next = taken;
            POL_DELAY: kill_next = 1'b0;
            default:   kill_next = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    // next state and outputs
    always_comb begin
        state_nxt = ST_RUN;
        sel       = SEL_SEQ;
        squash_o  = 1'b0;
        hold_o    = 1'b0;
        resolved  = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (is_xfer && dep_hit) begin
                    hold_o    = 1'b1;
                    sel       = SEL_HOLD;
                    state_nxt = ST_DEPWAIT;
                end else if (is_xfer) begin
                    resolved  = 1'b1;
                    sel       = taken ? SEL_TGT : SEL_SEQ;
                    state_nxt = kill_next ? ST_KILL : ST_RUN;
                end
            end
            ST_DEPWAIT: begin
                if (is_xfer) begin
                    resolved  = 1'b1;
                    sel       = taken ? SEL_TGT : SEL_SEQ;
                    state_nxt = kill_next ? ST_KILL : ST_RUN;
                end
            end
            ST_KILL: begin
                squash_o  = 1'b1;
                state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    assign pc_sel_o = sel;

    AST_SQUASH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |=> !squash_o); // R8
    AST_DEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o); // R4
    AST_STALL_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved && (pol == POL_STALL || pol == POL_RSVD)) |=> squash_o); // R5
    AST_PNT_KILL_IF_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved && pol == POL_PNT) |=> (squash_o == $past(taken))); // R6
    AST_DELAY_KEEPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (resolved && pol == POL_DELAY) |=> !squash_o); // R7
endmodule

// File: tb/sim_branch_resolve_ctl.sv
module sim_branch_resolve_ctl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  policy;
    logic        valid;
    logic [1:0]  kind;
    logic [4:0]  src;
    logic [31:0] opnd;
    logic [15:0] off;
    logic [31:0] seqpc;
    logic        exen;
    logic [4:0]  exreg;
    logic [1:0]  pc_sel;
    logic [31:0] tgt;
    logic        squash, hold;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // requirement model state
    bit    m_kill = 0;
    bit    m_dep  = 0;
    string m_tag  = "R1";

    always #10 clk = ~clk;

    branch_resolve_ctl u0 (
        .clk(clk), .rst_n(rst_n), .policy_i(policy), .id_valid_i(valid),
        .id_kind_i(kind), .id_src_reg_i(src), .id_operand_i(opnd),
        .id_offset_i(off), .id_seq_pc_i(seqpc), .ex_wr_en_i(exen),
        .ex_wr_reg_i(exreg), .pc_sel_o(pc_sel), .target_pc_o(tgt),
        .squash_o(squash), .hold_o(hold)
    );

    function automatic logic [31:0] exp_target(logic [31:0] s, logic [15:0] o);
        logic signed [31:0] so;
        so = 32'(signed'(o));
        return s + 32'(so * 4);
    endfunction

    function automatic bit exp_taken(logic [1:0] k, logic [31:0] v);
        return (k == 2'd3) || (k == 2'd1 && v == 0) || (k == 2'd2 && v != 0);
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(logic [1:0] p, logic v, logic [1:0] k, logic [4:0] s,
                        logic [31:0] o, logic [15:0] of, logic [31:0] sp,
                        logic we, logic [4:0] wr);
        bit    n_kill, n_dep, tk, dp, xf;
        string n_tag;
        @(negedge clk);
        policy = p; valid = v; kind = k; src = s; opnd = o; off = of;
        seqpc = sp; exen = we; exreg = wr;
        #3;
        n_kill = 0; n_dep = 0; n_tag = "R1";
        xf = v && (k != 2'd0);
        tk = exp_taken(k, o);
        if (m_kill) begin
            chk("R8", "sel", 32'(pc_sel), 32'd0);
            chk("R8", "hold", 32'(hold), 32'd0);
            chk(m_tag, "squash", 32'(squash), 32'd1);
            n_tag = "R8";
        end else begin
            chk(m_tag, "squash", 32'(squash), 32'd0);
            if (xf) begin
                chk("R2", "target", tgt, exp_target(sp, of));
                dp = !m_dep && (k != 2'd3) && we && (wr == s) && (s != 0);
                if (dp) begin
                    chk("R4", "sel", 32'(pc_sel), 32'd2);
                    chk("R4", "hold", 32'(hold), 32'd1);
                    n_dep = 1;
                end else begin
                    chk(m_dep ? "R4" : "R3", "sel", 32'(pc_sel), tk ? 32'd1 : 32'd0);
                    chk("R4", "hold", 32'(hold), 32'd0);
                    if (p == 2'd1) begin n_kill = tk; n_tag = "R6"; end
                    else if (p == 2'd2) begin n_kill = 0; n_tag = "R7"; end
                    else begin n_kill = 1; n_tag = "R5"; end
                end
            end else begin
                chk("R1", "sel", 32'(pc_sel), 32'd0);
                chk("R1", "hold", 32'(hold), 32'd0);
            end
        end
        @(posedge clk);
        m_kill = n_kill; m_dep = n_dep; m_tag = n_tag;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0]  rk;
        logic [4:0]  rs;
        logic [31:0] ro, rp;
        logic [15:0] rf;
        logic [1:0]  rpol;
        void'($urandom(32'h5EED_0042));
        rst_n = 0; policy = 0; valid = 0; kind = 0; src = 0; opnd = 0;
        off = 0; seqpc = 0; exen = 0; exreg = 0;
        repeat (2) @(posedge clk);
        #3;
        chk("R1", "reset sel", 32'(pc_sel), 32'd0);
        chk("R1", "reset squash", 32'(squash), 32'd0);
        chk("R1", "reset hold", 32'(hold), 32'd0);
        @(negedge clk); rst_n = 1;

        // R3 R6: predict not-taken, zero-test taken, negative offset (R2)
        step(2'd1, 1, 2'd1, 5'd3, 32'd0, 16'hFFFD, 32'h100, 0, 0);
        // R8: branch in squashed slot is ignored
        step(2'd1, 1, 2'd3, 5'd0, 32'd0, 16'h0010, 32'h104, 0, 0);
        step(2'd1, 0, 2'd0, 5'd0, 32'd0, 16'h0, 32'h108, 0, 0);
        // R6: not taken keeps successor
        step(2'd1, 1, 2'd2, 5'd6, 32'd0, 16'h0008, 32'h200, 0, 0);
        step(2'd1, 0, 2'd0, 5'd0, 32'd0, 16'h0, 32'h204, 0, 0);
        // R7: jump then branch in delay slot resolves
        step(2'd2, 1, 2'd3, 5'd0, 32'd0, 16'h7FFF, 32'h300, 0, 0);
        step(2'd2, 1, 2'd2, 5'd9, 32'd5, 16'h0004, 32'h304, 0, 0);
        step(2'd2, 0, 2'd0, 5'd0, 32'd0, 16'h0, 32'h308, 0, 0);
        // R5: stall policy and reserved code squash even when not taken
        step(2'd0, 1, 2'd1, 5'd2, 32'd7, 16'h0002, 32'h400, 0, 0);
        step(2'd0, 0, 2'd0, 5'd0, 32'd0, 16'h0, 32'h404, 0, 0);
        step(2'd3, 1, 2'd2, 5'd2, 32'd0, 16'h0002, 32'h500, 0, 0);
        step(2'd3, 0, 2'd0, 5'd0, 32'd0, 16'h0, 32'h504, 0, 0);
        // R4: dependence hold then resolve despite same execute inputs
        step(2'd1, 1, 2'd2, 5'd4, 32'd1, 16'h0020, 32'h600, 1, 5'd4);
        step(2'd1, 1, 2'd2, 5'd4, 32'd1, 16'h0020, 32'h600, 1, 5'd4);
        step(2'd1, 0, 2'd0, 5'd0, 32'd0, 16'h0, 32'h604, 0, 0);
        // R4: register zero and jumps never hold
        step(2'd2, 1, 2'd1, 5'd0, 32'd0, 16'h0001, 32'h700, 1, 5'd0);
        step(2'd2, 1, 2'd3, 5'd4, 32'd0, 16'h0001, 32'h704, 1, 5'd4);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            rpol = 2'($urandom_range(0, 3));
            rk   = 2'($urandom_range(0, 3));
            rs   = 5'($urandom_range(0, 3));
            ro   = ($urandom_range(0, 9) < 4) ? 32'd0 : $urandom;
            rf   = 16'($urandom);
            rp   = {$urandom, 2'b00} [31:0];
            step(rpol, ($urandom_range(0, 4) != 0), rk, rs, ro, rf, rp,
                 1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)));
            if (m_dep)
                step(rpol, 1, rk, rs, ro, rf, rp,
                     1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule